// File: doc/BRIEF.md
# Temperature-Stepped Fan PWM Controller

This block drives a cooling fan with a pulse-width modulated output. The high time in each fixed period comes from a width register. Software can write that register directly at any moment. An automatic policy also rewrites it from a 16-bit temperature code. The policy moves among five duty levels: 0, 25, 50, 75 and 100 percent of the period. Each level has a rising threshold to enter it from below and a falling threshold to return to it from above, so the duty does not chatter around a single crossing point.

A climb in duty caused by temperature raises a one-cycle temperature-rise pulse. The block then holds the new level for a settle window of `SETTLE_CYCLES` clocks, about five seconds of fan spin-up in a real system. Only after that window does it raise the duty-changed pulse. A software width write or a fall in level reports the duty change at once. Temperature codes map to degrees as code × 501.3743 / 65536 − 273.6777, and every threshold is written in that same code space.

The block stays inactive until bit 0 of its control register is set. While inactive, the PWM pin is low and neither event pulses.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: `period_out` always equals `PERIOD`. While enabled, the PWM pin is high for min(width, `PERIOD`) cycles in every `PERIOD` cycles. A width of 0 keeps the pin low, and a width of at least `PERIOD` keeps it high.
- R2: Writing select 0 sets the enable from `wr_data[0]`. While the enable is 0, the PWM pin is low, both event outputs stay low, and neither temperature nor width writes produce an event. Writing 0 returns the block to this state.
- R3: A write to select 1 loads the width from `wr_data`. When enabled, `pwm_chg_evt` is high for exactly the one cycle after the write edge.
- R4: When the temperature is strictly above the rising threshold of one or more levels above the current one, the level moves straight to the highest such level. The width becomes `PERIOD` × level / 4, and `temp_rise_evt` pulses for one cycle.
- R5: `pwm_chg_evt` rises exactly `SETTLE_CYCLES` cycles after `temp_rise_evt`. No level change happens during that window. A climb still pending afterwards is taken on the edge after the settle pulse.
- R6: When the temperature is strictly below the falling threshold of one or more levels under the current one, the level drops to the lowest such level. The width follows, and `pwm_chg_evt` pulses in the next cycle without `temp_rise_evt`.
- R7: A temperature between a level's falling threshold and the next rising threshold keeps the current level and width, with no events.
- R8: Selects 2 to 5 hold the rising thresholds of levels 1 to 4, and selects 6 to 9 hold the falling thresholds of levels 0 to 3. After reset, rising thresholds are 16'hFFFF and falling ones 0, so no automatic change happens before they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | DW | Temperature code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | DW | Write data |
| pwm_out | output | 1 | Fan PWM pin |
| period_out | output | DW | Fixed PWM period, read only |
| temp_rise_evt | output | 1 | Pulse: temperature raised the duty |
| pwm_chg_evt | output | 1 | Pulse: duty change has taken effect |

## Verification
A width write shows `pwm_chg_evt` in the cycle after its write edge, so the bench samples it just after that edge. It then samples again one cycle later to confirm the pulse is single.

A level fall sets `pwm_chg_evt` on the first edge after the new temperature is applied. A climb sets `temp_rise_evt` on that edge, and the bench then counts cycles until `pwm_chg_evt` appears, expecting exactly `SETTLE_CYCLES`.

The PWM pin is registered, so duty is measured only after `PERIOD`+2 settling cycles. The bench then counts high samples over one full period, which gives a result that does not depend on where the count starts within the period.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
  localparam int NSTEP = 4;
  localparam int LW    = 3;
  localparam int SELW  = 4;
  localparam logic [SELW-1:0] SEL_CTRL  = 4'd0;
  localparam logic [SELW-1:0] SEL_WIDTH = 4'd1;
  localparam int SEL_UP_BASE = 2;
  localparam int SEL_DN_BASE = 2 + NSTEP;

  typedef logic [LW-1:0] lvl_t;

  // High time for a level: an even share of the period per step.
  function automatic logic [31:0] level_width(input int unsigned period,
                                              input int unsigned lvl);
    return 32'((period * lvl) / NSTEP);
  endfunction
endpackage

// File: rtl/fan_thresh_regs.sv
module fan_thresh_regs
  import fanpwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SELW-1:0]            wr_sel,
  input  logic [DW-1:0]              wr_data,
  output logic [NSTEP-1:0][DW-1:0]   up_thr,
  output logic [NSTEP-1:0][DW-1:0]   dn_thr
);
  for (genvar i = 0; i < NSTEP; i++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_thr[i] <= '1;
        dn_thr[i] <= '0;
      end else if (wr_en) begin
        if (wr_sel == SELW'(SEL_UP_BASE + i)) up_thr[i] <= wr_data;
        if (wr_sel == SELW'(SEL_DN_BASE + i)) dn_thr[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/fan_temp_policy.sv
module fan_temp_policy
  import fanpwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]            temp,
  input  logic [NSTEP-1:0][DW-1:0] up_thr,
  input  logic [NSTEP-1:0][DW-1:0] dn_thr,
  input  lvl_t                     cur_lvl,
  output lvl_t                     tgt_lvl
);
  always_comb begin
    tgt_lvl = cur_lvl;
    // climb: ascending scan keeps the highest qualifying level
    for (int k = 1; k <= NSTEP; k++) begin
      if (LW'(k) > cur_lvl && temp > up_thr[k-1]) tgt_lvl = LW'(k);
    end
    // fall only when no climb: descending scan keeps the lowest level
    if (tgt_lvl == cur_lvl) begin
      for (int m = NSTEP - 1; m >= 0; m--) begin
        if (LW'(m) < cur_lvl && temp < dn_thr[m]) tgt_lvl = LW'(m);
      end
    end
  end
endmodule

// File: rtl/fan_settle_timer.sv
module fan_settle_timer #(
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(SETTLE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clear) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int DW     = 16,
  parameter int PERIOD = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] width,
  output logic          pwm
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pwm <= 1'b0;
    end else begin
      pwm <= en && (cnt < width);
      if (!en || cnt == DW'(PERIOD - 1)) cnt <= '0;
      else                               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fanpwm_pkg::*;
#(
  parameter int DW            = 16,
  parameter int PERIOD        = 100,
  parameter int SETTLE_CYCLES = 1000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   temp_code,
  input  logic            wr_en,
  input  logic [3:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic            pwm_out,
  output logic [DW-1:0]   period_out,
  output logic            temp_rise_evt,
  output logic            pwm_chg_evt
);
  logic en_q;
  logic [DW-1:0] width_q;
  lvl_t lvl_q, tgt_lvl;
  logic [NSTEP-1:0][DW-1:0] up_thr, dn_thr;
  logic settle_busy, settle_done;
  logic step, step_up, step_dn, sw_wr;

  assign period_out = DW'(PERIOD);

  fan_thresh_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .up_thr(up_thr), .dn_thr(dn_thr)
  );

  fan_temp_policy #(.DW(DW)) u_policy (
    .temp(temp_code), .up_thr(up_thr), .dn_thr(dn_thr),
    .cur_lvl(lvl_q), .tgt_lvl(tgt_lvl)
  );

  assign step    = en_q && !settle_busy && (tgt_lvl != lvl_q);
  assign step_up = step && (tgt_lvl > lvl_q);
  assign step_dn = step && (tgt_lvl < lvl_q);
  assign sw_wr   = wr_en && (wr_sel == SEL_WIDTH);

  fan_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .clear(!en_q), .start(step_up),
    .busy(settle_busy), .done(settle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q          <= 1'b0;
      width_q       <= '0;
      lvl_q         <= '0;
      temp_rise_evt <= 1'b0;
      pwm_chg_evt   <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_CTRL) en_q <= wr_data[0];
      if (step) lvl_q <= tgt_lvl;
      if (sw_wr)     width_q <= wr_data;
      else if (step) width_q <= DW'(level_width(PERIOD, 32'(tgt_lvl)));
      temp_rise_evt <= step_up;
      pwm_chg_evt   <= en_q && (sw_wr || step_dn || settle_done);
    end
  end

  fan_pwm_gen #(.DW(DW), .PERIOD(PERIOD)) u_pwm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .width(width_q), .pwm(pwm_out)
  );
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int DW            = 16,
  parameter int PERIOD        = 100,
  parameter int SETTLE_CYCLES = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic [DW-1:0] width_q,
  input logic [2:0]    lvl_q,
  input logic          settle_busy,
  input logic          pwm_out,
  input logic          temp_rise_evt,
  input logic          pwm_chg_evt
);
  localparam int GW = $clog2(SETTLE_CYCLES + 2);
  logic [GW-1:0] gap;
  logic gap_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_on <= 1'b0;
      gap    <= '0;
    end else if (!en_q) begin
      gap_on <= 1'b0;
    end else if (temp_rise_evt) begin
      gap_on <= 1'b1;
      gap    <= GW'(1);
    end else if (gap_on) begin
      if (gap == GW'(SETTLE_CYCLES)) gap_on <= 1'b0;
      else                           gap    <= gap + 1'b1;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !$past(en_q)) |-> (!pwm_out && !temp_rise_evt && !pwm_chg_evt));

  assert_full_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && $past(width_q) >= DW'(PERIOD)) |-> pwm_out);

  assert_zero_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(width_q) == '0) |-> !pwm_out);

  assert_rise_climbs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    temp_rise_evt |-> (lvl_q > $past(lvl_q)));

  assert_frozen_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(settle_busy) |-> (lvl_q == $past(lvl_q)));

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_on && en_q && gap == GW'(SETTLE_CYCLES)) |-> pwm_chg_evt);
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(
  .DW(DW), .PERIOD(PERIOD), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .width_q(width_q), .lvl_q(lvl_q),
  .settle_busy(settle_busy), .pwm_out(pwm_out),
  .temp_rise_evt(temp_rise_evt), .pwm_chg_evt(pwm_chg_evt)
);

// File: tb/tb_fan_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_fan_pwm_ctrl;
  localparam int DW = 16;
  localparam int PER = 8;
  localparam int SET = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] temp_code = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic pwm_out, temp_rise_evt, pwm_chg_evt;
  logic [DW-1:0] period_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fan_pwm_ctrl #(.DW(DW), .PERIOD(PER), .SETTLE_CYCLES(SET)) dut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out),
    .period_out(period_out), .temp_rise_evt(temp_rise_evt),
    .pwm_chg_evt(pwm_chg_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = DW'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic duty(output int highs);
    repeat (PER + 2) @(posedge clk);
    #1;
    highs = 0;
    for (int i = 0; i < PER; i++) begin
      @(posedge clk); #1;
      if (pwm_out) highs++;
    end
  endtask

  task automatic wait_rise(output int seen);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (temp_rise_evt) begin seen = 1; break; end
    end
  endtask

  task automatic to_chg(output int n, output int extra);
    n = 0; extra = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      n++;
      if (temp_rise_evt) extra++;
      if (pwm_chg_evt) break;
    end
  endtask

  task automatic quiet(output int evs);
    evs = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      if (temp_rise_evt || pwm_chg_evt) evs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h, n, x, s;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 period", int'(period_out), PER);
    chk("R2 reset pwm", int'(pwm_out), 0);
    chk("R2 reset events", int'(temp_rise_evt | pwm_chg_evt), 0);

    wr(1, 4);
    chk("R2 no event disabled", int'(pwm_chg_evt), 0);
    duty(h); chk("R2 pwm low disabled", h, 0);

    wr(0, 1);
    duty(h); chk("R1 width 4", h, 4);

    for (int w = 0; w <= 10; w++) begin
      wr(1, w);
      chk("R3 chg pulse", int'(pwm_chg_evt), 1);
      @(posedge clk); #1;
      chk("R3 single pulse", int'(pwm_chg_evt), 0);
      duty(h); chk("R1 sweep duty", h, (w < PER) ? w : PER);
    end
    wr(1, 0);

    temp_code = 16'hFFFF;
    quiet(s); chk("R8 reset thresholds inert", s, 0);
    temp_code = 16'd0;
    wr(2, 200); wr(3, 400); wr(4, 600); wr(5, 800);
    wr(6, 150); wr(7, 350); wr(8, 550); wr(9, 750);
    duty(h); chk("R8 no action at zero temp", h, 0);

    temp_code = 16'd250;
    wait_rise(s); chk("R4 rise to level 1", s, 1);
    temp_code = 16'd450;
    to_chg(n, x);
    chk("R5 settle length", n, SET);
    chk("R5 frozen during settle", x, 0);
    @(posedge clk); #1;
    chk("R5 pending climb after settle", int'(temp_rise_evt), 1);
    to_chg(n, x); chk("R5 second settle", n, SET);
    duty(h); chk("R4 level 2 duty", h, PER / 2);

    temp_code = 16'd900;
    wait_rise(s); chk("R4 jump rise", s, 1);
    to_chg(n, x); chk("R4 jump single rise", x, 0);
    duty(h); chk("R4 full duty", h, PER);

    temp_code = 16'd700;
    @(posedge clk); #1;
    chk("R6 drop chg", int'(pwm_chg_evt), 1);
    chk("R6 drop no rise", int'(temp_rise_evt), 0);
    duty(h); chk("R6 level 3 duty", h, 3 * PER / 4);

    temp_code = 16'd620;
    quiet(s); chk("R7 hold at 620", s, 0);
    temp_code = 16'd560;
    quiet(s); chk("R7 hold at 560", s, 0);
    duty(h); chk("R7 level 3 kept", h, 3 * PER / 4);

    temp_code = 16'd100;
    @(posedge clk); #1;
    chk("R6 multi drop chg", int'(pwm_chg_evt), 1);
    duty(h); chk("R6 drop to zero", h, 0);

    wr(1, PER);
    wr(0, 0);
    temp_code = 16'd900;
    duty(h); chk("R2 disabled pwm", h, 0);
    quiet(s); chk("R2 disabled events", s, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule